// File: doc/BRIEF.md
# Processor Control Register Decoder

This block sits on the I/O page of a 16-bit processor and answers word and byte accesses to a small set of control registers. These are the processor status word, the stack limit, the microprogram break register, the CPU error register, the maintenance register, the console switch/display register, a fixed system identification word and a two-word system size value. Each register has its own rule for writes: some bits are masked, some are forced, one register clears on any write, and some are read-only. The block returns read data one clock after a request. Word accesses to odd addresses and accesses to addresses that decode to no register produce a one-cycle trap pulse that carries the trap vector.

A requester presents a single-cycle request made of an address, a byte/word flag, a write enable and write data. The status word and stack limit live here as plain registers. Error causes from elsewhere in the processor arrive as level flags that latch into the CPU error register.

Top module: `sysctl_regs`

## Requirements
- R1: A read request (req_valid=1, req_we=0) that decodes and does not fault loads rd_data on the next clock edge. rd_data is stable in every cycle without such a read. With no request, trap_valid is 0 in the following cycle.
- R2: Any write to the status word (word address 0o177776) stores the data with bit 4, the trace bit, forced to 0.
- R3: A byte write (req_byte=1) to the status word, stack limit (0o177774), microprogram break (0o177770) or console display replaces only the half chosen by address bit 0 (1 = upper byte) and keeps the other half. A byte read returns the addressed half in bits 7:0, with bits 15:8 set to zero.
- R4: A word write to the stack limit stores the upper byte and sets the lower byte to 0x00. Any byte write to it sets the lower byte to 0xFF.
- R5: A word write to the microprogram break register keeps only data bits 7:0 and stores the upper byte as zero.
- R6: The 8-bit CPU error register (0o177766) ORs in err_flags every cycle. A write to it, whatever its data, clears it, and err_flags of that same cycle are still taken in. A byte read at either of its addresses returns the 8 error bits.
- R7: The maintenance register (0o177750) reads 1. The identification register (0o177764) reads 0o011064. Writes to either complete without a trap and change nothing.
- R8: The system size value is MEM_BYTES/64 - 1. Its low word reads at 0o177760 and its high word at 0o177762. Writes there are ignored.
- R9: A read of the console register (0o177570) returns sw_in. A write to it sets led_out.
- R10: A word access to an odd address raises trap_valid in the next cycle, with trap_odd=1 and trap_vector=0o004. The access changes no register and leaves rd_data unchanged.
- R11: An access to an even address, or a byte access, that matches no register raises trap_valid with trap_odd=0 and trap_vector=0o004.
- R12: After reset, rd_data, led_out, trap_valid and every writable register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 16 | Byte address in the I/O page |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| err_flags | input | 8 | Error causes latched into the CPU error register |
| sw_in | input | 16 | Console switch inputs |
| rd_data | output | 16 | Registered read data |
| led_out | output | 16 | Console display outputs |
| trap_valid | output | 1 | One-cycle trap request |
| trap_odd | output | 1 | Trap cause is an odd word access |
| trap_vector | output | 8 | Trap vector, 0o004 |

## Verification
The status word, stack limit and break register each receive word writes and byte writes to both halves, with data that sets the trace bit and the low byte. This separates a correct half merge from a whole-word overwrite and shows that each forcing rule acts on its own path. The error register is written with and without err_flags active in the same cycle, which tells the clear apart from the set. Odd word accesses, odd byte accesses and unmapped even addresses are then mixed with accesses to real registers, which separates odd-address traps from decode misses and shows that faulting writes leave the state intact.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [15:0] A_PSW    = 16'o177776;
  localparam logic [15:0] A_STKLIM = 16'o177774;
  localparam logic [15:0] A_MPBRK  = 16'o177770;
  localparam logic [15:0] A_CPUERR = 16'o177766;
  localparam logic [15:0] A_SYSID  = 16'o177764;
  localparam logic [15:0] A_SIZEHI = 16'o177762;
  localparam logic [15:0] A_SIZELO = 16'o177760;
  localparam logic [15:0] A_MAINT  = 16'o177750;
  localparam logic [15:0] A_CONS   = 16'o177570;

  localparam logic [15:0] SYSID_VAL = 16'o011064;
  localparam logic [7:0]  TRAP_VEC  = 8'o004;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PSW, SEL_STK, SEL_MPB, SEL_ERR,
    SEL_ID, SEL_SZHI, SEL_SZLO, SEL_MAINT, SEL_CONS
  } sel_e;

  function automatic logic [15:0] merge_half(input logic [15:0] old,
                                             input logic [7:0] b,
                                             input logic hi);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  function automatic logic [15:0] psw_next(input logic [15:0] old, input logic [15:0] d,
                                           input logic byte_acc, input logic hi);
    logic [15:0] v;
    v = byte_acc ? merge_half(old, d[7:0], hi) : d;
    v[4] = 1'b0;
    return v;
  endfunction

  function automatic logic [15:0] stk_next(input logic [15:0] old, input logic [15:0] d,
                                           input logic byte_acc, input logic hi);
    return byte_acc ? (merge_half(old, d[7:0], hi) | 16'h00FF) : {d[15:8], 8'h00};
  endfunction

  function automatic logic [15:0] mpb_next(input logic [15:0] old, input logic [15:0] d,
                                           input logic byte_acc, input logic hi);
    return byte_acc ? merge_half(old, d[7:0], hi) : {8'h00, d[7:0]};
  endfunction

  function automatic logic [31:0] size_value(input longint unsigned mem_bytes);
    return 32'(mem_bytes / 64 - 1);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        byte_acc,
  output sel_e        sel,
  output logic        odd_fault
);
  logic [15:0] even_addr;
  assign even_addr = {addr[15:1], 1'b0};
  assign odd_fault = !byte_acc && addr[0];

  always_comb begin
    case (even_addr)
      A_PSW:    sel = SEL_PSW;
      A_STKLIM: sel = SEL_STK;
      A_MPBRK:  sel = SEL_MPB;
      A_CPUERR: sel = SEL_ERR;
      A_SYSID:  sel = SEL_ID;
      A_SIZEHI: sel = SEL_SZHI;
      A_SIZELO: sel = SEL_SZLO;
      A_MAINT:  sel = SEL_MAINT;
      A_CONS:   sel = SEL_CONS;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  sel_e             sel,
  input  logic             byte_acc,
  input  logic             hi,
  input  logic [15:0]      wdata,
  input  logic [ERR_W-1:0] err_flags,
  output logic [15:0]      psw_q,
  output logic [15:0]      stk_q,
  output logic [15:0]      mpb_q,
  output logic [ERR_W-1:0] err_q,
  output logic [15:0]      led_q
);
  logic wr_psw, wr_stk, wr_mpb, wr_err, wr_led;
  assign wr_psw = wr_en && sel == SEL_PSW;
  assign wr_stk = wr_en && sel == SEL_STK;
  assign wr_mpb = wr_en && sel == SEL_MPB;
  assign wr_err = wr_en && sel == SEL_ERR;
  assign wr_led = wr_en && sel == SEL_CONS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_q <= '0;
      stk_q <= '0;
      mpb_q <= '0;
      err_q <= '0;
      led_q <= '0;
    end else begin
      if (wr_psw) psw_q <= psw_next(psw_q, wdata, byte_acc, hi);
      if (wr_stk) stk_q <= stk_next(stk_q, wdata, byte_acc, hi);
      if (wr_mpb) mpb_q <= mpb_next(mpb_q, wdata, byte_acc, hi);
      if (wr_led) led_q <= byte_acc ? merge_half(led_q, wdata[7:0], hi) : wdata;
      err_q <= wr_err ? err_flags : (err_q | err_flags);
    end
  end

  a_r2_trace_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_psw |=> !psw_q[4]);
  a_r3_psw_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_psw && byte_acc && hi) |=> psw_q[7:0] == ($past(psw_q[7:0]) & 8'hEF));
  a_r4_stk_byte_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stk && byte_acc) |=> stk_q[7:0] == 8'hFF);
  a_r4_stk_word_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stk && !byte_acc) |=> stk_q[7:0] == 8'h00);
  a_r5_mpb_word_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mpb && !byte_acc) |=> mpb_q[15:8] == 8'h00);
  a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> err_q == $past(err_flags));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd4194304,
  parameter int              ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_addr,
  input  logic             req_byte,
  input  logic             req_we,
  input  logic [15:0]      req_wdata,
  input  logic [ERR_W-1:0] err_flags,
  input  logic [15:0]      sw_in,
  output logic [15:0]      rd_data,
  output logic [15:0]      led_out,
  output logic             trap_valid,
  output logic             trap_odd,
  output logic [7:0]       trap_vector
);
  localparam logic [31:0] SIZE_VAL = size_value(MEM_BYTES);

  sel_e        sel;
  logic        odd_fault;
  logic        miss_fault;
  logic        fault;
  logic        wr_ok;
  logic        rd_ok;
  logic [15:0] psw_q, stk_q, mpb_q, led_q;
  logic [ERR_W-1:0] err_q;
  logic [15:0] word_val;
  logic [15:0] rd_val;

  sysctl_decode u_decode (
    .addr      (req_addr),
    .byte_acc  (req_byte),
    .sel       (sel),
    .odd_fault (odd_fault)
  );

  assign miss_fault = sel == SEL_NONE;
  assign fault      = odd_fault || miss_fault;
  assign wr_ok      = req_valid && req_we && !fault;
  assign rd_ok      = req_valid && !req_we && !fault;

  sysctl_store #(.ERR_W(ERR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ok),
    .sel       (sel),
    .byte_acc  (req_byte),
    .hi        (req_addr[0]),
    .wdata     (req_wdata),
    .err_flags (err_flags),
    .psw_q     (psw_q),
    .stk_q     (stk_q),
    .mpb_q     (mpb_q),
    .err_q     (err_q),
    .led_q     (led_q)
  );

  always_comb begin
    case (sel)
      SEL_PSW:   word_val = psw_q;
      SEL_STK:   word_val = stk_q;
      SEL_MPB:   word_val = mpb_q;
      SEL_ERR:   word_val = 16'(err_q);
      SEL_ID:    word_val = SYSID_VAL;
      SEL_SZHI:  word_val = SIZE_VAL[31:16];
      SEL_SZLO:  word_val = SIZE_VAL[15:0];
      SEL_MAINT: word_val = 16'd1;
      SEL_CONS:  word_val = sw_in;
      default:   word_val = '0;
    endcase
    if (!req_byte)            rd_val = word_val;
    else if (sel == SEL_ERR)  rd_val = 16'(err_q[7:0]);
    else if (req_addr[0])     rd_val = {8'h00, word_val[15:8]};
    else                      rd_val = {8'h00, word_val[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= '0;
      trap_valid  <= 1'b0;
      trap_odd    <= 1'b0;
      trap_vector <= '0;
    end else begin
      if (rd_ok) rd_data <= rd_val;
      trap_valid  <= req_valid && fault;
      trap_odd    <= req_valid && odd_fault;
      trap_vector <= (req_valid && fault) ? TRAP_VEC : 8'h00;
    end
  end

  assign led_out = led_q;

  a_r10_odd_word_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_byte && req_addr[0]) |=> (trap_valid && trap_odd && trap_vector == 8'o004));
  a_r11_miss_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte && miss_fault) |=> (trap_valid && !trap_odd && trap_vector == 8'o004));
  a_r1_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !trap_valid);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rd_data));
  a_r7_id_constant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !req_byte && req_addr == 16'o177764) |=> rd_data == 16'o011064);
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  err_flags = '0;
  logic [15:0] sw_in = '0;
  logic [15:0] rd_data, led_out;
  logic        trap_valid, trap_odd;
  logic [7:0]  trap_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] o_rd;
  logic        o_trap, o_odd;
  logic [7:0]  o_vec;

  always #10 clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_byte(req_byte), .req_we(req_we), .req_wdata(req_wdata),
    .err_flags(err_flags), .sw_in(sw_in), .rd_data(rd_data), .led_out(led_out),
    .trap_valid(trap_valid), .trap_odd(trap_odd), .trap_vector(trap_vector)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic b, input logic w, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = b; req_we = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    o_rd = rd_data; o_trap = trap_valid; o_odd = trap_odd; o_vec = trap_vector;
  endtask

  task automatic wr(input logic [15:0] a, input logic b, input logic [15:0] d);
    access(a, b, 1'b1, d);
  endtask

  task automatic rd(input logic [15:0] a, input logic b);
    access(a, b, 1'b0, 16'h0000);
  endtask

  task automatic t_reset;
    chk("R12 rd_data", rd_data, 16'h0);
    chk("R12 led_out", led_out, 16'h0);
    chk("R12 trap", {15'h0, trap_valid}, 16'h0);
    rd(16'o177776, 1'b0); chk("R12 psw", o_rd, 16'h0);
    rd(16'o177774, 1'b0); chk("R12 stklim", o_rd, 16'h0);
    rd(16'o177766, 1'b0); chk("R12 cpuerr", o_rd, 16'h0);
  endtask

  task automatic t_psw;
    wr(16'o177776, 1'b0, 16'hFFFF);
    rd(16'o177776, 1'b0); chk("R2 word write clears trace", o_rd, 16'hFFEF);
    wr(16'o177777, 1'b1, 16'h0012);
    rd(16'o177776, 1'b0); chk("R3 psw upper byte", o_rd, 16'h12EF);
    wr(16'o177776, 1'b1, 16'h005A);
    rd(16'o177776, 1'b0); chk("R2 R3 psw lower byte trace", o_rd, 16'h124A);
    rd(16'o177777, 1'b1); chk("R3 byte read upper", o_rd, 16'h0012);
    rd(16'o177776, 1'b1); chk("R3 byte read lower", o_rd, 16'h004A);
    chk("R1 no trap on read", {15'h0, o_trap}, 16'h0);
    @(negedge clk); @(negedge clk);
    chk("R1 rd_data held", rd_data, 16'h004A);
  endtask

  task automatic t_stklim;
    wr(16'o177774, 1'b0, 16'h1234);
    rd(16'o177774, 1'b0); chk("R4 word write", o_rd, 16'h1200);
    wr(16'o177774, 1'b1, 16'h0055);
    rd(16'o177774, 1'b0); chk("R4 byte low forced", o_rd, 16'h12FF);
    wr(16'o177775, 1'b1, 16'h0077);
    rd(16'o177774, 1'b0); chk("R3 R4 byte high", o_rd, 16'h77FF);
  endtask

  task automatic t_mpb;
    wr(16'o177770, 1'b0, 16'hBEEF);
    rd(16'o177770, 1'b0); chk("R5 word keeps low", o_rd, 16'h00EF);
    wr(16'o177771, 1'b1, 16'h00C3);
    rd(16'o177770, 1'b0); chk("R3 mpb high byte", o_rd, 16'hC3EF);
  endtask

  task automatic t_cpuerr;
    @(negedge clk); err_flags = 8'h24;
    @(negedge clk); err_flags = 8'h00;
    rd(16'o177766, 1'b0); chk("R6 flags latched", o_rd, 16'h0024);
    rd(16'o177767, 1'b1); chk("R6 byte read odd", o_rd, 16'h0024);
    wr(16'o177766, 1'b0, 16'h0000);
    rd(16'o177766, 1'b0); chk("R6 write clears", o_rd, 16'h0000);
    @(negedge clk); err_flags = 8'h81;
    @(negedge clk); err_flags = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'o177766; req_byte = 1'b1; req_we = 1'b1; req_wdata = 16'h00FF;
    err_flags = 8'h01;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; err_flags = 8'h00;
    rd(16'o177766, 1'b0); chk("R6 clear with set same cycle", o_rd, 16'h0001);
  endtask

  task automatic t_fixed;
    rd(16'o177750, 1'b0); chk("R7 maint", o_rd, 16'h0001);
    rd(16'o177764, 1'b0); chk("R7 sysid", o_rd, 16'o011064);
    wr(16'o177764, 1'b0, 16'h0000); chk("R7 sysid write no trap", {15'h0, o_trap}, 16'h0);
    rd(16'o177764, 1'b0); chk("R7 sysid after write", o_rd, 16'o011064);
    wr(16'o177750, 1'b0, 16'h0000);
    rd(16'o177750, 1'b0); chk("R7 maint after write", o_rd, 16'h0001);
  endtask

  task automatic t_size;
    rd(16'o177760, 1'b0); chk("R8 size low", o_rd, 16'hFFFF);
    rd(16'o177762, 1'b0); chk("R8 size high", o_rd, 16'h0000);
    wr(16'o177762, 1'b0, 16'h1111);
    rd(16'o177762, 1'b0); chk("R8 size high after write", o_rd, 16'h0000);
    rd(16'o177761, 1'b1); chk("R8 size low byte upper", o_rd, 16'h00FF);
  endtask

  task automatic t_console;
    sw_in = 16'h5A5A;
    rd(16'o177570, 1'b0); chk("R9 switches", o_rd, 16'h5A5A);
    wr(16'o177570, 1'b0, 16'h1357); chk("R9 leds", led_out, 16'h1357);
    wr(16'o177571, 1'b1, 16'h00AB); chk("R3 R9 led high byte", led_out, 16'hAB57);
  endtask

  task automatic t_odd;
    rd(16'o177776, 1'b0);
    rd(16'o177777, 1'b0);
    chk("R10 trap", {15'h0, o_trap}, 16'h1);
    chk("R10 odd", {15'h0, o_odd}, 16'h1);
    chk("R10 vector", {8'h0, o_vec}, 16'o004);
    chk("R10 rd_data held", o_rd, 16'h124A);
    wr(16'o177775, 1'b0, 16'h0000);
    chk("R10 write trap", {15'h0, o_trap}, 16'h1);
    rd(16'o177774, 1'b0); chk("R10 stklim untouched", o_rd, 16'h77FF);
    chk("R1 trap is one cycle", {15'h0, o_trap}, 16'h0);
  endtask

  task automatic t_unmapped;
    rd(16'o000400, 1'b0);
    chk("R11 trap", {15'h0, o_trap}, 16'h1);
    chk("R11 not odd", {15'h0, o_odd}, 16'h0);
    chk("R11 vector", {8'h0, o_vec}, 16'o004);
    rd(16'o177701, 1'b1);
    chk("R11 byte miss trap", {15'h0, o_trap}, 16'h1);
    chk("R11 byte miss not odd", {15'h0, o_odd}, 16'h0);
    wr(16'o177702, 1'b0, 16'hFFFF);
    chk("R11 write miss trap", {15'h0, o_trap}, 16'h1);
    rd(16'o177776, 1'b0); chk("R11 psw untouched", o_rd, 16'h124A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_psw();
    t_stklim();
    t_mpb();
    t_cpuerr();
    t_fixed();
    t_size();
    t_console();
    t_odd();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule